// File: doc/BRIEF.md
# Accumulator ALU With Flags

This block is the arithmetic core of a small 8-bit accumulator machine. Each cycle it combines the accumulator byte with an operand byte under a 3-bit operation select, or rotates the accumulator in one of four ways when a rotate is requested. It presents the new accumulator value together with a write strobe. It keeps four registered status flags: carry, zero, sign and parity. The carry that feeds add-with-carry, subtract-with-borrow and the through-carry rotates is the registered carry flag.

The surrounding sequencer picks the operand source and decides when the accumulator is written, using the write strobe. It raises the enable on the cycle the result should commit to the flags. A separate 3-bit condition select is tested against the registered flags, and the outcome decides conditional jumps, calls and returns.

Top module: `acc_alu_flags`

## Requirements
- R1: Operation 000 gives acc+opnd and operation 001 gives acc+opnd+carry, both modulo 256. The carry flag takes the ninth bit of the sum.
- R2: Operation 010 gives acc-opnd and operation 011 gives acc-opnd-carry, both modulo 256. The carry flag is set when a borrow occurs, meaning the subtrahend (with borrow-in) exceeds the accumulator.
- R3: Operation 100 is AND, 101 is XOR and 110 is OR. Each of them clears the carry flag.
- R4: Operation 111 (compare) deasserts the accumulator write strobe. Its flags are those of acc-opnd, with carry set when opnd > acc. Every other operation and every rotate asserts the write strobe.
- R5: For the eight operations, zero is set when the flag result is 0 and sign is copied from bit 7 of that result. Parity is 1 when the result has an even number of ones.
- R6: With the rotate request high, rotate select 00 rotates left with bit 7 going to both bit 0 and carry. Select 01 rotates right with bit 0 going to both bit 7 and carry.
- R7: Rotate select 10 rotates left through carry: the old carry goes into bit 0 and bit 7 goes into carry. Select 11 rotates right through carry: the old carry goes into bit 7 and bit 0 goes into carry.
- R8: A rotate updates only the carry flag. Zero, sign and parity keep their previous values.
- R9: The condition output tests one flag, chosen by the select's low two bits: 00 carry, 01 zero, 10 sign, 11 parity. Select bit 2 set means the condition is true when the flag is 1; bit 2 clear means it is true when the flag is 0.
- R10: Flags change only on a rising clock edge with the enable high. An active-low reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Commit flags on this edge |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Operand byte |
| op_sel | input | 3 | Arithmetic/logic operation |
| rot_req | input | 1 | Perform a rotate instead of op_sel |
| rot_sel | input | 2 | Rotate form |
| cond_sel | input | 3 | Condition to evaluate |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write strobe |
| carry_q | output | 1 | Carry flag |
| zero_q | output | 1 | Zero flag |
| sign_q | output | 1 | Sign flag |
| parity_q | output | 1 | Parity flag (1 = even) |
| cond_true | output | 1 | Condition outcome |

## Verification
The assertions assume that op_sel, rot_req and rot_sel are stable and known whenever en is high. They also assume the surrounding logic treats a rotate as overriding the operation select. The stimulus meets this by driving every input on the falling edge, so all inputs hold steady through the sampling edge. Random stimulus covers all operation, rotate and condition codes, toggles the enable and carries the carry from one step into the next. Directed steps add the wrap-around, borrow and zero-result corners.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int W = 8;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000, OP_ADC = 3'b001, OP_SUB = 3'b010, OP_SBB = 3'b011,
    OP_AND = 3'b100, OP_XOR = 3'b101, OP_OR  = 3'b110, OP_CMP = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    RT_LCIRC = 2'b00, RT_RCIRC = 2'b01, RT_LTHRU = 2'b10, RT_RTHRU = 2'b11
  } rot_e;

  typedef struct packed {
    logic [W-1:0] res;
    logic         cout;
  } alu_res_t;

  function automatic alu_res_t f_arith(input logic [2:0] op, input logic [W-1:0] a,
                                       input logic [W-1:0] b, input logic cin);
    alu_res_t r;
    logic [W:0] wide;
    wide = '0;
    unique case (op)
      OP_ADD: wide = {1'b0, a} + {1'b0, b};
      OP_ADC: wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      OP_SUB, OP_CMP: wide = {1'b0, a} - {1'b0, b};
      OP_SBB: wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      OP_AND: wide = {1'b0, a & b};
      OP_XOR: wide = {1'b0, a ^ b};
      default: wide = {1'b0, a | b};
    endcase
    r.res  = wide[W-1:0];
    r.cout = wide[W];
    return r;
  endfunction

  function automatic alu_res_t f_rotate(input logic [1:0] sel, input logic [W-1:0] a,
                                        input logic cin);
    alu_res_t r;
    unique case (sel)
      RT_LCIRC: begin r.res = {a[W-2:0], a[W-1]}; r.cout = a[W-1]; end
      RT_RCIRC: begin r.res = {a[0], a[W-1:1]};   r.cout = a[0];   end
      RT_LTHRU: begin r.res = {a[W-2:0], cin};    r.cout = a[W-1]; end
      default:  begin r.res = {cin, a[W-1:1]};    r.cout = a[0];   end
    endcase
    return r;
  endfunction

  function automatic logic f_even(input logic [W-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
  import acc_alu_pkg::*;
(
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic [2:0]   op_sel,
  input  logic         rot_req,
  input  logic [1:0]   rot_sel,
  input  logic         cin,
  output logic [W-1:0] acc_out,
  output logic         acc_we,
  output logic         cout,
  output logic [W-1:0] flag_res,
  output logic         upd_all
);
  alu_res_t ar, rr;

  always_comb begin
    ar = f_arith(op_sel, acc_in, opnd_in, cin);
    rr = f_rotate(rot_sel, acc_in, cin);
    if (rot_req) begin
      acc_out  = rr.res;
      cout     = rr.cout;
      acc_we   = 1'b1;
      upd_all  = 1'b0;
      flag_res = rr.res;
    end else begin
      acc_out  = (op_sel == OP_CMP) ? acc_in : ar.res;
      cout     = ar.cout;
      acc_we   = (op_sel != OP_CMP);
      upd_all  = 1'b1;
      flag_res = ar.res;
    end
  end

  always_comb begin
    if (!rot_req && op_sel == OP_CMP)
      AST_CMP_KEEPS_ACC: assert (acc_out == acc_in); // R4
  end
endmodule

// File: rtl/acc_flag_reg.sv
module acc_flag_reg
  import acc_alu_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         upd_all,
  input  logic         cout,
  input  logic [W-1:0] flag_res,
  output logic         carry_q,
  output logic         zero_q,
  output logic         sign_q,
  output logic         parity_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q  <= 1'b0;
      zero_q   <= 1'b0;
      sign_q   <= 1'b0;
      parity_q <= 1'b0;
    end else if (en) begin
      carry_q <= cout;
      if (upd_all) begin
        zero_q   <= (flag_res == '0);
        sign_q   <= flag_res[W-1];
        parity_q <= f_even(flag_res);
      end
    end
  end

  AST_ROT_HOLDS_ZSP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !upd_all) |=> ($stable(zero_q) && $stable(sign_q) && $stable(parity_q))); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(carry_q) && $stable(zero_q) && $stable(sign_q) && $stable(parity_q))); // R10
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd_all) |=> (zero_q == ($past(flag_res) == '0))); // R5
endmodule

// File: rtl/acc_cond_eval.sv
module acc_cond_eval (
  input  logic [2:0] cond_sel,
  input  logic       carry_q,
  input  logic       zero_q,
  input  logic       sign_q,
  input  logic       parity_q,
  output logic       cond_true
);
  logic picked;
  always_comb begin
    unique case (cond_sel[1:0])
      2'b00:   picked = carry_q;
      2'b01:   picked = zero_q;
      2'b10:   picked = sign_q;
      default: picked = parity_q;
    endcase
    cond_true = cond_sel[2] ? picked : ~picked;
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [7:0]   acc_in,
  input  logic [7:0]   opnd_in,
  input  logic [2:0]   op_sel,
  input  logic         rot_req,
  input  logic [1:0]   rot_sel,
  input  logic [2:0]   cond_sel,
  output logic [7:0]   acc_out,
  output logic         acc_we,
  output logic         carry_q,
  output logic         zero_q,
  output logic         sign_q,
  output logic         parity_q,
  output logic         cond_true
);
  logic         cout;
  logic [W-1:0] flag_res;
  logic         upd_all;

  acc_arith_unit u_arith (
    .acc_in(acc_in), .opnd_in(opnd_in), .op_sel(op_sel), .rot_req(rot_req),
    .rot_sel(rot_sel), .cin(carry_q), .acc_out(acc_out), .acc_we(acc_we),
    .cout(cout), .flag_res(flag_res), .upd_all(upd_all)
  );

  acc_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .en(en), .upd_all(upd_all), .cout(cout),
    .flag_res(flag_res), .carry_q(carry_q), .zero_q(zero_q), .sign_q(sign_q),
    .parity_q(parity_q)
  );

  acc_cond_eval u_cond (
    .cond_sel(cond_sel), .carry_q(carry_q), .zero_q(zero_q), .sign_q(sign_q),
    .parity_q(parity_q), .cond_true(cond_true)
  );

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_req && op_sel == OP_CMP) |-> !acc_we); // R4
  AST_LOGIC_CLR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rot_req && op_sel[2] && op_sel != OP_CMP) |=> !carry_q); // R3
  AST_CMP_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rot_req && op_sel == OP_CMP) |=> (carry_q == ($past(opnd_in) > $past(acc_in)))); // R4
endmodule

// File: tb/acc_alu_flags_tb.sv
module acc_alu_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic [2:0] op_sel = '0, cond_sel = '0;
  logic rot_req = 1'b0;
  logic [1:0] rot_sel = '0;
  logic [7:0] acc_out;
  logic acc_we, carry_q, zero_q, sign_q, parity_q, cond_true;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  bit mc = 0, mz = 0, ms = 0, mp = 0;

  always #4 clk = ~clk;

  acc_alu_flags u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .acc_in(acc_in), .opnd_in(opnd_in),
    .op_sel(op_sel), .rot_req(rot_req), .rot_sel(rot_sel), .cond_sel(cond_sel),
    .acc_out(acc_out), .acc_we(acc_we), .carry_q(carry_q), .zero_q(zero_q),
    .sign_q(sign_q), .parity_q(parity_q), .cond_true(cond_true)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  // expected result value (as int), carry and write flag
  function automatic void model(input int a, input int b, input int op, input bit rr,
                                input int rs, input bit c, output int res, output bit co,
                                output bit we, output bit all);
    int t;
    we = 1; all = !rr;
    if (rr) begin
      case (rs)
        0: begin co = a[7]; res = ((a * 2) % 256) + a[7]; end
        1: begin co = a[0]; res = (a / 2) + 128 * a[0]; end
        2: begin co = a[7]; res = ((a * 2) % 256) + c; end
        default: begin co = a[0]; res = (a / 2) + 128 * c; end
      endcase
    end else begin
      case (op)
        0: t = a + b;
        1: t = a + b + c;
        2, 7: t = a - b;
        3: t = a - b - c;
        4: t = a & b;
        5: t = a ^ b;
        default: t = a | b;
      endcase
      co = (t > 255) || (t < 0);
      res = (t + 512) % 256;
      if (op == 7) we = 0;
    end
  endfunction

  task automatic step(input int a, input int b, input int op, input bit rr, input int rs,
                      input int cs, input bit e);
    int res; bit co, we, all, f;
    acc_in = a[7:0]; opnd_in = b[7:0]; op_sel = op[2:0]; rot_req = rr;
    rot_sel = rs[1:0]; cond_sel = cs[2:0]; en = e;
    #1;
    model(a, b, op, rr, rs, mc, res, co, we, all);
    case (cs % 4)
      0: f = mc; 1: f = mz; 2: f = ms; default: f = mp;
    endcase
    chk("R9 cond", cond_true, (cs >= 4) ? f : !f);
    chk(rr ? (rs < 2 ? "R6 rot" : "R7 rot") : (op < 2 ? "R1 acc" : op < 4 ? "R2 acc" : "R3 acc"),
        (rr || op != 7) ? acc_out : res, res);
    chk("R4 we", acc_we, we);
    if (e) begin
      mc = co;
      if (all) begin mz = (res == 0); ms = res[7]; mp = (ones(res) % 2 == 0); end
    end
    @(posedge clk); #1;
    chk(rr ? "R7 carry" : (op < 2 ? "R1 carry" : op == 7 ? "R4 carry" : op < 4 ? "R2 carry" : "R3 carry"),
        carry_q, mc);
    chk(rr ? "R8 zero" : (e ? "R5 zero" : "R10 zero"), zero_q, mz);
    chk(rr ? "R8 sign" : "R5 sign", sign_q, ms);
    chk(rr ? "R8 parity" : "R5 parity", parity_q, mp);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 reset", {carry_q, zero_q, sign_q, parity_q}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(8'hFF, 8'h01, 0, 0, 0, 4, 1);   // R1 wrap to zero, carry, even parity
    step(8'h10, 8'h20, 2, 0, 0, 0, 1);   // R2 borrow
    step(8'h05, 8'h05, 3, 0, 0, 5, 1);   // R2 with borrow-in
    step(8'h80, 8'h80, 1, 0, 0, 4, 1);   // R1 adc
    step(8'h0F, 8'hF0, 4, 0, 0, 1, 1);   // R3 AND to zero, carry cleared
    step(8'h40, 8'h41, 7, 0, 0, 6, 1);   // R4 compare borrow
    step(8'h81, 8'h00, 0, 1, 0, 3, 1);   // R6 left circular
    step(8'h81, 8'h00, 0, 1, 1, 7, 1);   // R6 right circular
    step(8'h00, 8'h00, 0, 1, 2, 0, 1);   // R7/R8 left through carry
    step(8'h01, 8'h00, 0, 1, 3, 2, 1);   // R7/R8 right through carry
    step(8'h33, 8'h77, 0, 0, 0, 1, 0);   // R10 enable low holds
    for (int i = 0; i < 3000; i++)
      step($urandom % 256, $urandom % 256, $urandom % 8, ($urandom % 4) == 0,
           $urandom % 4, $urandom % 8, ($urandom % 8) != 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule